// File: doc/BRIEF.md
# Space-Flag Line Expander

This block turns one stored line of text into exactly one display row of character codes. Lines are kept compactly in byte memory. The top bit of each stored byte marks whether a word gap follows that character, so inter-word spaces take no storage. A zero byte closes the line. After a start pulse with the line's base address, the block reads the bytes in order and sends out the 7-bit code of each character. It inserts a space code wherever the flag asks for one and fills the rest of the row with blanks once the line has ended.

The output is a valid/ready stream into the row's character offset registers. The block must finish a whole row within the two blank scan lines between text rows. For that reason it sustains one character per clock: each byte read is issued one clock ahead of the character it feeds, and a two-entry buffer absorbs stalls on the output side. When the row's last position has been handed over, a one-clock done pulse follows.

Top module: `line_expander`

## Requirements
- R1: Reads start at the base address and step by one. A read byte of 0x00 ends the line, and no address beyond the one holding 0x00 is read for that row.
- R2: Every non-zero byte produces one output code equal to its bits 6..0.
- R3: When bit 7 of a non-zero byte is 0, the next output code is 0x20, unless that character took the last position of the row.
- R4: Each row delivers exactly ROW_LEN (default 40) codes. Positions after the terminating 0x00 carry 0x20.
- R5: Once ROW_LEN codes have been transferred, expansion stops and any implied space still pending is discarded. `row_done_o` is high for exactly the one clock that follows the final transfer.
- R6: With `ch_ready_i` held high, the ROW_LEN transfers of a row occur on consecutive clocks, counted from the first one.
- R7: Read data is taken one clock after `rd_en_o`, and the address for the next byte is issued while the current character is being emitted.
- R8: While `ch_valid_o` is high and `ch_ready_i` is low, `ch_code_o` holds its value and the row does not advance.
- R9: A start pulse that arrives while a row is in progress is ignored. The row in progress completes unchanged.
- R10: After reset, `ch_valid_o`, `rd_en_o` and `row_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-clock request to expand a line |
| base_addr_i | input | ADDR_W | Address of the line's first byte |
| rd_en_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_data_i | input | 8 | Read data, valid one clock after `rd_en_o` |
| ch_valid_o | output | 1 | Output code available |
| ch_ready_i | input | 1 | Consumer accepts the code |
| ch_code_o | output | 7 | Character code |
| row_done_o | output | 1 | One-clock pulse after the last code of the row |

## Verification
The assertions rely on the line memory answering every read exactly one clock later with a stable byte. They also rely on the consumer sampling codes only on clocks where both valid and ready are high. The bench's memory model is a register with one clock of latency, and its ready pattern changes only between clock edges, so every assertion sees inputs of that kind. Start pulses last one clock. The pulse sent during a busy row is there only to exercise the ignore rule.

// File: rtl/lx_pkg.sv
// Shared constants for the line expander: byte and code widths and the blank code.
package lx_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 7;
    localparam logic [CODE_W-1:0] BLANK_CODE = 7'h20;
endpackage

// File: rtl/lx_fifo.sv
// lx_fifo: small byte buffer between the memory return path and the emitter.
// Assumes the caller never pushes into a full buffer unless it pops in the same
// clock, and never pops while empty. A flush empties it, and flush wins over push.
module lx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign dout  = slot_q[rd_q];
    assign empty = (count == '0);

    // Purpose: store pushed bytes in the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_q] <= din;
    end

    // Purpose: move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (count < CNT_W'(DEPTH))); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
endmodule

// File: rtl/lx_fetch.sv
// lx_fetch: issues sequential byte reads one clock ahead of use and returns the
// bytes into the buffer. Assumes read data arrives one clock after a request.
// It stops requesting as soon as a zero byte comes back, including in the very
// clock it arrives, so no address beyond the terminator is requested.
module lx_fetch #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     busy,
    input  logic [lx_pkg::BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]         buf_count,
    input  logic                     buf_pop,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     buf_push
);
    logic inflight_q;
    logic stop_q;
    logic null_now;
    int   occ_after;

    assign null_now = inflight_q && (rd_data == '0);
    assign buf_push = inflight_q;

    // Purpose: request the next byte only if the buffer has room for it when it returns.
    always_comb begin
        occ_after = int'(buf_count) + int'(inflight_q) - int'(buf_pop);
        rd_en = busy && !stop_q && !null_now && (occ_after < DEPTH);
    end

    // Purpose: track the outstanding read, the terminator latch and the address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
            stop_q     <= 1'b0;
            rd_addr    <= '0;
        end else if (launch) begin
            inflight_q <= 1'b0;
            stop_q     <= 1'b0;
            rd_addr    <= base_addr;
        end else begin
            inflight_q <= rd_en;
            if (null_now) stop_q <= 1'b1;
            if (rd_en) rd_addr <= rd_addr + ADDR_W'(1);
        end
    end

    AST_STOP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !launch) |=> stop_q); // R1
endmodule

// File: rtl/lx_emit.sv
// lx_emit: walks the row's columns. Each clock it offers the head byte's code,
// a pending implied blank, or padding once the line has ended. Assumes the head
// byte stays stable while the buffer is not popped. A zero head byte is consumed
// as the first padding column, so no bubble appears at the terminator.
module lx_emit #(
    parameter int ROW_LEN = 40,
    localparam int COL_W = $clog2(ROW_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic                      head_valid,
    input  logic [lx_pkg::BYTE_W-1:0] head,
    input  logic                      ready,
    output logic                      valid,
    output logic [lx_pkg::CODE_W-1:0] code,
    output logic                      pop,
    output logic                      busy,
    output logic                      ended,
    output logic                      row_done
);
    import lx_pkg::*;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);

    logic [COL_W-1:0] col_q;
    logic             gap_q;
    logic             fire;
    logic             head_null;

    assign head_null = (head == '0);

    // Purpose: pick what this column shows and whether the head byte is consumed.
    always_comb begin
        valid = busy && (ended || gap_q || head_valid);
        code  = (ended || gap_q || head_null) ? BLANK_CODE : head[CODE_W-1:0];
        fire  = valid && ready;
        pop   = fire && !ended && !gap_q;
    end

    // Purpose: advance the column, the pending-gap flag and the end-of-line flag on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            col_q    <= '0;
            gap_q    <= 1'b0;
            ended    <= 1'b0;
            row_done <= 1'b0;
        end else begin
            row_done <= 1'b0;
            if (launch) begin
                busy  <= 1'b1;
                col_q <= '0;
                gap_q <= 1'b0;
                ended <= 1'b0;
            end else if (fire) begin
                col_q <= col_q + COL_W'(1);
                if (col_q == LAST_COL) begin
                    busy     <= 1'b0;
                    row_done <= 1'b1;
                end
                if (gap_q) gap_q <= 1'b0;
                else if (pop) begin
                    if (head_null) ended <= 1'b1;
                    else           gap_q <= !head[BYTE_W-1];
                end
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && code == $past(code))); // R8
    AST_GAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !head_null && !head[BYTE_W-1] && col_q != LAST_COL) |=> (valid && code == BLANK_CODE)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done); // R5
    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_W'(ROW_LEN)); // R4
endmodule

// File: rtl/line_expander.sv
// line_expander: expands one flag-compressed text line into a fixed-width row
// of 7-bit character codes. Assumes a byte memory with one clock of read
// latency and a one-clock start pulse. Start is ignored while a row is active.
module line_expander #(
    parameter int ADDR_W  = 8,
    parameter int ROW_LEN = 40,
    parameter int BUF_DEPTH = 2,
    localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              ch_valid_o,
    input  logic              ch_ready_i,
    output logic [6:0]        ch_code_o,
    output logic              row_done_o
);
    logic             launch;
    logic             busy;
    logic             ended;
    logic             buf_push, buf_pop, buf_empty;
    logic [7:0]       buf_head;
    logic [CNT_W-1:0] buf_count;

    assign launch = start_i && !busy;

    lx_fetch #(.ADDR_W(ADDR_W), .DEPTH(BUF_DEPTH)) fetch_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .base_addr(base_addr_i),
        .busy(busy), .rd_data(rd_data_i), .buf_count(buf_count), .buf_pop(buf_pop),
        .rd_en(rd_en_o), .rd_addr(rd_addr_o), .buf_push(buf_push)
    );

    lx_fifo #(.DEPTH(BUF_DEPTH), .W(8)) buf_i (
        .clk(clk), .rst_n(rst_n), .flush(launch), .push(buf_push), .din(rd_data_i),
        .pop(buf_pop), .dout(buf_head), .empty(buf_empty), .count(buf_count)
    );

    lx_emit #(.ROW_LEN(ROW_LEN)) emit_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .head_valid(!buf_empty),
        .head(buf_head), .ready(ch_ready_i), .valid(ch_valid_o), .code(ch_code_o),
        .pop(buf_pop), .busy(busy), .ended(ended), .row_done(row_done_o)
    );

    AST_QUIET_AFTER_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        ended |-> !rd_en_o); // R1
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ch_valid_o && !rd_en_o)); // R10
endmodule

// File: tb/line_expander_tb_top.sv
module line_expander_tb_top;
    localparam int ROW = 40;
    localparam int LOG = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] base = '0;
    logic       rd_en;
    logic [7:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic       valid;
    logic       ready = 1'b0;
    logic [6:0] code;
    logic       row_done;

    logic [7:0] mem [256];
    int cyc = 0;
    int nvec = 0, nfail = 0;
    int ready_mode = 1;
    logic [15:0] lfsr = 16'hACE1;

    // logs written only by the monitor
    int rd_log [LOG];
    int code_log [LOG];
    int fire_cyc [LOG];
    int done_cyc [LOG];
    int n_rd = 0, n_code = 0, n_done = 0, hold_bad = 0;
    logic hold_pend = 1'b0;
    logic [6:0] hold_code = '0;

    int exp_code [ROW];
    int exp_null;

    always #5 clk = ~clk;

    line_expander dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .ch_valid_o(valid), .ch_ready_i(ready), .ch_code_o(code), .row_done_o(row_done)
    );

    // memory with one clock of read latency (R7)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // ready pattern, changed just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready = (ready_mode == 1) ? 1'b1 : (lfsr[0] | lfsr[2]);
        end
    end

    // monitor samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !(valid && code == hold_code)) hold_bad <= hold_bad + 1;
            hold_pend <= valid && !ready;
            hold_code <= code;
            if (rd_en && n_rd < LOG) begin rd_log[n_rd] <= int'(rd_addr); n_rd <= n_rd + 1; end
            if (valid && ready && n_code < LOG) begin
                code_log[n_code] <= int'(code);
                fire_cyc[n_code] <= cyc;
                n_code <= n_code + 1;
            end
            if (row_done && n_done < LOG) begin done_cyc[n_done] <= cyc; n_done <= n_done + 1; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // expected row computed from the stored bytes
    task automatic build_expected(input int b);
        int col = 0;
        int i = 0;
        exp_null = -1;
        while (col < ROW) begin
            int v = int'(mem[(b + i) % 256]);
            if (v == 0) begin exp_null = i; break; end
            exp_code[col] = v % 128;
            col++;
            if (v < 128 && col < ROW) begin exp_code[col] = 32; col++; end
            i++;
        end
        while (col < ROW) begin exp_code[col] = 32; col++; end
    endtask

    task automatic run_row(input int b, input int mode, input bit restart);
        int s_rd, s_code, s_done, s_hold, waited;
        int got_rd, got_code, got_done;
        bit rd_ok;
        build_expected(b);
        ready_mode = mode;
        @(posedge clk);
        #2;
        s_rd = n_rd; s_code = n_code; s_done = n_done; s_hold = hold_bad;
        start = 1'b1; base = 8'(b);
        @(posedge clk);
        #2;
        start = 1'b0;
        if (restart) begin
            repeat (6) @(posedge clk);
            #2;
            start = 1'b1; base = 8'(b + 97);
            @(posedge clk);
            #2;
            start = 1'b0;
        end
        waited = 0;
        while (n_done == s_done && waited < 3000) begin @(posedge clk); waited++; end
        repeat (4) @(posedge clk);
        #2;
        got_rd = n_rd - s_rd; got_code = n_code - s_code; got_done = n_done - s_done;
        check(got_code == ROW, "R4 column count", got_code, ROW);
        for (int c = 0; c < ROW && c < got_code; c++)
            check(code_log[s_code + c] == exp_code[c], restart ? "R9 code" : "R2/R3/R4 code",
                  code_log[s_code + c], exp_code[c]);
        check(got_done == 1, "R5 done pulses", got_done, 1);
        if (got_done >= 1 && got_code >= 1)
            check(done_cyc[s_done] == fire_cyc[s_code + got_code - 1] + 1, "R5 done timing",
                  done_cyc[s_done] - fire_cyc[s_code + got_code - 1], 1);
        rd_ok = 1'b1;
        for (int j = 0; j < got_rd; j++)
            if (rd_log[s_rd + j] != (b + j) % 256) rd_ok = 1'b0;
        check(rd_ok, "R1 sequential addresses", got_rd, b);
        if (exp_null >= 0)
            check(got_rd == exp_null + 1, "R1 reads stop at null", got_rd, exp_null + 1);
        if (mode == 1 && got_code == ROW)
            check(fire_cyc[s_code + ROW - 1] - fire_cyc[s_code] == ROW - 1, "R6 one per clock",
                  fire_cyc[s_code + ROW - 1] - fire_cyc[s_code], ROW - 1);
        check(hold_bad == s_hold, "R8 stall hold", hold_bad - s_hold, 0);
        check(!valid && !rd_en, "R5 idle after row", {30'd0, valid, rd_en}, 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'hC1;
        repeat (3) @(posedge clk);
        #2;
        check(!valid && !rd_en && !row_done, "R10 reset outputs", {29'd0, valid, rd_en, row_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check(!valid && !rd_en && !row_done, "R10 idle after reset", {29'd0, valid, rd_en, row_done}, 0);

        // mixed flags with a terminator at 12 (R2, R3, R4)
        for (int k = 0; k < 12; k++) mem[k] = 8'((8'h41 + k) | ((k % 3 == 2) ? 8'h00 : 8'h80));
        mem[12] = 8'h00;
        run_row(0, 1, 1'b0);
        run_row(0, 0, 1'b0);

        // empty line: all blanks, one read (R1, R4)
        mem[64] = 8'h00;
        run_row(64, 1, 1'b0);

        // no terminator, all flags set: 40 characters (R2, R5)
        for (int k = 0; k < 50; k++) mem[100 + k] = 8'(8'hA1 + (k % 60));
        run_row(100, 1, 1'b0);

        // every byte implies a gap: last column is a blank (R3)
        for (int k = 0; k < 25; k++) mem[160 + k] = 8'(8'h61 + (k % 26));
        run_row(160, 0, 1'b0);

        // 40th character carries a gap that must be dropped, then next row starts clean (R5)
        for (int k = 0; k < 39; k++) mem[200 + k] = 8'hB0 + 8'(k % 10);
        mem[239] = 8'h58;
        mem[240] = 8'hDA;
        run_row(200, 1, 1'b0);
        mem[20] = 8'hD1; mem[21] = 8'h00;
        run_row(20, 1, 1'b0);

        // start during a busy row is ignored (R9)
        for (int k = 0; k < 8; k++) mem[30 + k] = 8'(8'h30 + k);
        mem[38] = 8'h00;
        run_row(30, 0, 1'b1);

        // sweep of terminator position 0..40 with varied flags, both ready modes
        for (int p = 0; p <= ROW; p++) begin
            for (int k = 0; k < p; k++)
                mem[k] = 8'((((k * 37 + p * 11) % 94) + 33) | (((k + p) % 4 == 0) ? 0 : 128));
            mem[p] = 8'h00;
            run_row(0, p % 2, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
        $finish;
    end
endmodule